// File: doc/BRIEF.md
# Serial Shifter with In-Stream Latch Window

This block streams frames of bytes to a chain of serial-input driver chips over a shift clock and a data line. Alongside the data it drives a latch line. The latch is not a strobe issued after the shift has finished. It is held high across a chosen run of bit times near the end of the frame, while those same bits are still being shifted out. The length of that run and its distance from the frame's end tell the receiving chips which of their internal registers should take the data. Because the latch rides inside the data stream, frames can follow each other with no idle bit times between them.

Bytes arrive on a valid/ready stream. A byte is accepted on any system clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on the block's state, never on `in_valid`. It is high while the block is idle, and during the final system cycle of the last bit of the byte being shifted. If the source holds `in_valid` high, that timing gives gapless output. If the source withholds data, the shift clock parks low and the latch is dropped until the next byte arrives.

Each frame is described by three values: its length in bytes, the index of the window's first bit counted backwards from the frame's last bit (index 0 is the final bit), and the window width. All three are taken from the inputs when the first byte of a frame is accepted. The shift clock period is twice `half_cycles` system cycles. `frame_bytes` must be at least 1.

Top module: `latch_window_shifter`

## Requirements
- R1: Each accepted byte is sent as 8 consecutive bits on `ser_data`, most significant bit first, and frames are sent in the order their bytes are accepted.
- R2: `ser_clk` is low for `half_cycles` system cycles and then high for `half_cycles` system cycles for every bit. `ser_data` and `ser_latch` never change on a cycle where `ser_clk` rises.
- R3: `ser_latch` is high at the rising edge of exactly those bits whose index from the frame end `k` satisfies `win_start <= k < win_start + win_width`. For example, start 0 with width 2 covers the last two bits of the frame, and start 2 with width 2 covers bits five and six of the final byte.
- R4: `frame_bytes`, `win_start` and `win_width` are sampled when a frame's first byte is accepted. Changing them later in that frame has no effect on it.
- R5: While `in_valid` stays high, consecutive rising edges of `ser_clk` are exactly `2*half_cycles` system cycles apart, both within a frame and across a frame boundary.
- R6: `in_ready` is high whenever no byte is loaded, and otherwise only during the last system cycle of a byte's final bit. An accepted byte's first bit appears on the next cycle, with `ser_clk` low.
- R7: If no byte is offered when a byte ends, `ser_clk` and `ser_latch` stay low until one is accepted, and the frame then resumes with the correct data and window.
- R8: `frame_done` pulses high for one system cycle, on the cycle when `ser_clk` falls after the frame's final bit. This is `half_cycles` cycles after that bit's rising edge.
- R9: While `rst` is high, `ser_clk`, `ser_data`, `ser_latch`, `frame_done` and `in_ready` are low. After reset the block is idle with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte offered on the stream |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block accepts a byte on this edge |
| frame_bytes | input | LEN_W | Frame length in bytes, sampled at frame start |
| win_start | input | 8 | Window start, bits counted back from the frame's last bit |
| win_width | input | 5 | Window width in bits (1 to 16) |
| half_cycles | input | HALF_W | System cycles per half period of `ser_clk` |
| ser_clk | output | 1 | Shift clock to the driver chips |
| ser_data | output | 1 | Serial data, changes while `ser_clk` falls |
| ser_latch | output | 1 | Latch window line |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
A byte accepted on edge E puts its first bit on `ser_data` after E. `ser_clk` rises `half_cycles` edges later and falls a further `half_cycles` edges later, when the next bit, or `frame_done`, appears. The bench drives and samples on the falling edge of the system clock and time-stamps every observed rise of `ser_clk`. The bit and latch values captured at those rises are compared with a stream built from the requirements. The spacing between stamps is checked against `2*half_cycles`. The `frame_done` stamp must equal the last rise stamp plus `half_cycles`.

// File: rtl/lws_pkg.sv
package lws_pkg;
  localparam int START_W = 8;
  localparam int WIDTH_W = 5;

  typedef struct packed {
    logic [START_W-1:0] start;
    logic [WIDTH_W-1:0] width;
  } win_cfg_t;
endpackage

// File: rtl/lws_phase.sv
module lws_phase #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half_cycles,
  output logic              half_end
);
  logic [HALF_W-1:0] cnt_q;

  // a zero setting behaves like one
  assign half_end = run && (({1'b0, cnt_q} + 1'b1) >= {1'b0, half_cycles});

  always_ff @(posedge clk) begin
    if (rst || !run || half_end) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lws_window.sv
module lws_window
  import lws_pkg::*;
#(
  parameter int REM_W = 11
) (
  input  logic [REM_W-1:0] rem,
  input  win_cfg_t         cfg,
  output logic             hit
);
  localparam int CW = ((REM_W > START_W) ? REM_W : START_W) + 1;

  logic [CW-1:0] r, s, w;

  always_comb begin
    r   = CW'(rem);
    s   = CW'(cfg.start);
    w   = CW'(cfg.width);
    hit = (r >= s) && ((r - s) < w);
  end
endmodule

// File: rtl/latch_window_shifter.sv
module latch_window_shifter
  import lws_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int HALF_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         in_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LEN_W-1:0]   frame_bytes,
  input  logic [START_W-1:0] win_start,
  input  logic [WIDTH_W-1:0] win_width,
  input  logic [HALF_W-1:0]  half_cycles,
  output logic               ser_clk,
  output logic               ser_data,
  output logic               ser_latch,
  output logic               frame_done
);
  localparam int REM_W = LEN_W + 3;

  logic             busy_q, in_frame_q;
  logic             sclk_q, sdata_q, latch_q, done_q;
  logic [6:0]       shreg_q;
  logic [2:0]       bitcnt_q;
  logic [REM_W-1:0] rem_q;
  win_cfg_t         cfg_q;

  logic             half_end, byte_end, take, new_frame, next_hit;
  logic [REM_W-1:0] start_rem, next_rem;
  win_cfg_t         next_cfg;

  lws_phase #(.HALF_W(HALF_W)) u_phase (
    .clk(clk), .rst(rst), .run(busy_q),
    .half_cycles(half_cycles), .half_end(half_end)
  );

  // end of the high half of a byte's last bit
  assign byte_end  = busy_q && sclk_q && half_end && (bitcnt_q == 3'd0);
  assign in_ready  = !rst && (!busy_q || byte_end);
  assign take      = in_ready && in_valid;
  assign new_frame = !in_frame_q || (byte_end && (rem_q == '0));
  assign start_rem = {frame_bytes, 3'b000} - 1'b1;

  always_comb begin
    next_rem = rem_q - 1'b1;
    next_cfg = cfg_q;
    if (take && new_frame) begin
      next_rem = start_rem;
      next_cfg = '{start: win_start, width: win_width};
    end
  end

  lws_window #(.REM_W(REM_W)) u_window (
    .rem(next_rem), .cfg(next_cfg), .hit(next_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      in_frame_q <= 1'b0;
      sclk_q     <= 1'b0;
      sdata_q    <= 1'b0;
      latch_q    <= 1'b0;
      done_q     <= 1'b0;
      shreg_q    <= '0;
      bitcnt_q   <= '0;
      rem_q      <= '0;
      cfg_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        busy_q     <= 1'b1;
        in_frame_q <= 1'b1;
        sclk_q     <= 1'b0;
        sdata_q    <= in_data[7];
        shreg_q    <= in_data[6:0];
        bitcnt_q   <= 3'd7;
        rem_q      <= next_rem;
        cfg_q      <= next_cfg;
        latch_q    <= next_hit;
        if (byte_end && (rem_q == '0)) done_q <= 1'b1;
      end else if (busy_q && half_end) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bitcnt_q != 3'd0) begin
            sdata_q  <= shreg_q[6];
            shreg_q  <= {shreg_q[5:0], 1'b0};
            bitcnt_q <= bitcnt_q - 1'b1;
            rem_q    <= next_rem;
            latch_q  <= next_hit;
          end else begin
            // byte finished with nothing offered: park
            busy_q  <= 1'b0;
            sdata_q <= 1'b0;
            latch_q <= 1'b0;
            if (rem_q == '0) begin
              done_q     <= 1'b1;
              in_frame_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign ser_clk    = sclk_q;
  assign ser_data   = sdata_q;
  assign ser_latch  = latch_q;
  assign frame_done = done_q;

  p_edge_stable_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> ($stable(ser_data) && $stable(ser_latch)));

  p_take_low_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!ser_clk && busy_q));

  p_park_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!ser_clk && !ser_latch));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  p_done_clk_low_r8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !ser_clk);
endmodule

// File: tb/latch_window_shifter_tb.sv
`timescale 1ns/1ps
module latch_window_shifter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] frame_bytes = 8'd1;
  logic [7:0] win_start = '0;
  logic [4:0] win_width = 5'd1;
  logic [7:0] half_cycles = 8'd1;
  logic       ser_clk, ser_data, ser_latch, frame_done;

  latch_window_shifter u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .frame_bytes(frame_bytes), .win_start(win_start),
    .win_width(win_width), .half_cycles(half_cycles), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_latch(ser_latch), .frame_done(frame_done)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: samples on falling system-clock edges
  int cap_t[0:511];
  logic cap_d[0:511], cap_l[0:511];
  int cap_n = 0, done_cnt = 0, done_t = 0;
  logic prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (ser_clk && !prev_sclk) begin
      cap_t[cap_n] <= cyc;
      cap_d[cap_n] <= ser_data;
      cap_l[cap_n] <= ser_latch;
      cap_n <= cap_n + 1;
    end
    if (frame_done) begin
      done_cnt <= done_cnt + 1;
      done_t <= cyc;
    end
    prev_sclk <= ser_clk;
  end

  logic exp_d[0:511], exp_l[0:511];
  int exp_n = 0;
  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [7:0] seed, input int i);
    return seed + 8'(i * 59) ^ 8'(i << 4);
  endfunction

  task automatic send_byte(input logic [7:0] b);
    in_data = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic add_expected(input int len, input int st, input int wd, input logic [7:0] seed);
    for (int j = 0; j < len * 8; j++) begin
      logic [7:0] b;
      int k;
      b = byte_of(seed, j / 8);
      k = len * 8 - 1 - j;
      exp_d[exp_n] = b[7 - (j % 8)];
      exp_l[exp_n] = (k >= st) && (k < st + wd);
      exp_n++;
    end
  endtask

  task automatic send_frame(input int len, input int st, input int wd, input int h,
                            input logic [7:0] seed);
    frame_bytes = 8'(len);
    win_start = 8'(st);
    win_width = 5'(wd);
    half_cycles = 8'(h);
    add_expected(len, st, wd, seed);
    for (int i = 0; i < len; i++) send_byte(byte_of(seed, i));
  endtask

  task automatic compare(input int cb, input int eb, input int db, input int h,
                         input int ndone, input int gap_at);
    int bad_d = 0, bad_l = 0, bad_g = 0;
    check(cap_n - cb == exp_n - eb, "R1 bit count", cap_n - cb, exp_n - eb);
    for (int i = 0; i < exp_n - eb && i < cap_n - cb; i++) begin
      if (cap_d[cb + i] !== exp_d[eb + i]) bad_d++;
      if (cap_l[cb + i] !== exp_l[eb + i]) bad_l++;
    end
    for (int i = cb + 1; i < cap_n; i++)
      if (i - cb != gap_at && cap_t[i] - cap_t[i - 1] != 2 * h) bad_g++;
    check(bad_d == 0, "R1 data bits", bad_d, 0);
    check(bad_l == 0, "R3 latch window", bad_l, 0);
    check(bad_g == 0, "R5 edge spacing", bad_g, 0);
    check(done_cnt - db == ndone, "R8 done count", done_cnt - db, ndone);
    check(done_t == cap_t[cap_n - 1] + h, "R8 done timing", done_t, cap_t[cap_n - 1] + h);
  endtask

  // {len, start, width, half, seed}
  localparam logic [36:0] VEC [5] = '{
    {8'd6,  8'd0,  5'd2,  8'd1, 8'hA5},
    {8'd12, 8'd2,  5'd2,  8'd2, 8'h3C},
    {8'd1,  8'd0,  5'd8,  8'd1, 8'hF0},
    {8'd3,  8'd5,  5'd16, 8'd3, 8'h17},
    {8'd2,  8'd15, 5'd1,  8'd1, 8'h81}
  };

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int cb, eb, db;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!ser_clk && !ser_data && !ser_latch && !frame_done, "R9 outputs in reset",
          {ser_clk, ser_data, ser_latch, frame_done}, 0);
    check(!in_ready, "R9 ready in reset", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready, "R9 ready after reset", in_ready, 1);
    check(!ser_clk && !ser_latch, "R9 idle lines", {ser_clk, ser_latch}, 0);

    // vector table: R1 R2 R3 R5 R6 R8
    foreach (VEC[v]) begin
      cb = cap_n; eb = exp_n; db = done_cnt;
      send_frame(int'(VEC[v][36:29]), int'(VEC[v][28:21]), int'(VEC[v][20:16]),
                 int'(VEC[v][15:8]), VEC[v][7:0]);
      repeat (20 * int'(VEC[v][15:8]) + 8) @(negedge clk);
      compare(cb, eb, db, int'(VEC[v][15:8]), 1, -1);
    end

    // R4 R5: two frames back to back, second config set while the first still shifts
    cb = cap_n; eb = exp_n; db = done_cnt;
    send_frame(2, 0, 2, 1, 8'h5A);
    send_frame(2, 2, 2, 1, 8'hC3);
    repeat (30) @(negedge clk);
    compare(cb, eb, db, 1, 2, -1);
    check(cap_t[cb + 16] - cap_t[cb + 15] == 2, "R5 no gap at frame boundary",
          cap_t[cb + 16] - cap_t[cb + 15], 2);

    // R7: source stalls between bytes of one frame; whole frame in the window
    cb = cap_n; eb = exp_n; db = done_cnt;
    frame_bytes = 8'd2; win_start = 8'd0; win_width = 5'd16; half_cycles = 8'd1;
    add_expected(2, 0, 16, 8'h66);
    send_byte(byte_of(8'h66, 0));
    repeat (24) @(negedge clk);
    check(!ser_clk && !ser_latch, "R7 parked lines low", {ser_clk, ser_latch}, 0);
    check(in_ready, "R6 ready while parked", in_ready, 1);
    check(done_cnt == db, "R7 no done mid-frame", done_cnt - db, 0);
    send_byte(byte_of(8'h66, 1));
    repeat (30) @(negedge clk);
    compare(cb, eb, db, 1, 1, 8);
    check(cap_t[cb + 8] - cap_t[cb + 7] > 2, "R7 clock held during stall",
          cap_t[cb + 8] - cap_t[cb + 7], 3);

    // R9: reset mid-frame
    frame_bytes = 8'd4; win_start = 8'd0; win_width = 5'd16;
    in_data = 8'hFF; in_valid = 1'b1;
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(!ser_clk && !ser_data && !ser_latch, "R9 reset clears lines",
          {ser_clk, ser_data, ser_latch}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(!ser_clk && in_ready, "R9 idle after reset", {ser_clk, in_ready}, 1);
    finish_run();
  end
endmodule